// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

The controller gathers level-sensitive interrupt requests from two banks and presents them to a processor as one level-sensitive request line. The primary bank holds 40 sources, spread over two 32-bit register words. The secondary bank holds 32 sources. Its enabled pending bits are ORed together and feed primary source 0, so the whole secondary bank appears to the processor as one primary line.

Software uses a simple 32-bit register bus. A write takes effect at the clock edge where it is presented. Read data appears on the cycle after the read strobe. Each bank has a write-1-to-set enable register, a write-1-to-clear enable register and a write-1-to-clear pending register. An index register gives the lowest-numbered active primary source above 0. When it reads 0, only the cascade line is active, and software clears primary pending bit 0 and then reads the secondary status word. A set of plain storage registers is kept as read/write state: a channel map with one entry per primary source, polarity and type words, and two spare words.

Top module: `cascade_irqc`

## Requirements
- R1: After reset, every pending bit, enable bit and storage register reads 0, and irq_out is 0. Channel map entries read 0 until they are first written.
- R2: Writing the primary enable-set words (0x020 for sources 0-31, 0x024 for sources 32-39) sets the enable bits that have a 1. Writing the enable-clear words (0x030, 0x034) clears them. Zero bits leave enables unchanged. Reads of 0x020/0x030 (and 0x024/0x034) return the enable mask, and bits 31:8 of the upper word read 0.
- R3: A primary pending bit is set on any clock edge where its source is high, whether or not the source is enabled. Pending reads at 0x000/0x004 and also at 0x010/0x014. Source n is bit n mod 32 of word n/32.
- R4: A 1 written to a pending-clear word (0x010/0x014 primary, 0x088 secondary) makes that pending bit 0 on the following cycle, and the bit latches again on the next edge if the source is still high.
- R5: The index word at 0x040 returns, in bits 5:0, the lowest source number n>=1 that is both pending and enabled. It returns 0 when there is none, and bits 31:6 always read 0.
- R6: The level of primary source 0 is prim_src[0] ORed with the OR of all secondary pending bits ANDed with their enables. The secondary raw pending word reads at 0x080 and 0x088. The secondary enable is set at 0x090, cleared at 0x098, and its mask reads at both offsets.
- R7: irq_out is high on the cycle after any primary pending bit is set together with its enable bit, and low on the cycle after none is.
- R8: The spare words at 0x044 and 0xA0 hold all 32 bits. The polarity words (0x050/0x054) and type words (0x060/0x064) hold one bit per primary source. Channel map entry ch at 0x200+4*ch (ch 0..39) holds a 6-bit value, and bits 31:6 read 0.
- R9: bus_rdata is valid the cycle after bus_rd. Unmapped addresses, channel offsets beyond entry 39 and addresses with bits 1:0 not zero read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| prim_src | input | 40 | Primary source levels (bit 0 shares the cascade line) |
| sec_src | input | 32 | Secondary source levels |
| irq_out | output | 1 | Level interrupt request to the processor |

## Verification
Primary sources are raised in mixes of enabled and disabled sources, in the lower word, in the upper word and in both at once. This shows that pending latching does not depend on enable, while the index and irq_out do, and it confirms that the lowest-numbered source wins. A pending-clear is read back on the very next cycle and again later, first with the source held high and then with it dropped, which separates the one-cycle drop from a lasting clear. The secondary bank is exercised with its enable off, then on with primary 0 masked, then fully unmasked. This separates the raw status from the cascade term and from the processor line. Storage registers, out-of-range channel offsets and partial upper words are read back, and this exposes bits that are wrongly kept or wrongly dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW        = 32;
  localparam int NPRI_DEF  = 40;
  localparam int NSEC_DEF  = 32;
  localparam int AW_DEF    = 12;
  // word addresses (byte address / 4)
  localparam int W_PSTAT   = 'h00;
  localparam int W_PCLR    = 'h04;
  localparam int W_PSET    = 'h08;
  localparam int W_PENCLR  = 'h0C;
  localparam int W_INDEX   = 'h10;
  localparam int W_SPARE0  = 'h11;
  localparam int W_POL     = 'h14;
  localparam int W_TYP     = 'h18;
  localparam int W_SSTAT   = 'h20;
  localparam int W_SCLR    = 'h22;
  localparam int W_SSET    = 'h24;
  localparam int W_SENCLR  = 'h26;
  localparam int W_SPARE1  = 'h28;
  localparam int W_CHMAP   = 'h80;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  input  logic [W-1:0] pd_clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
    end else begin
      en   <= (en | en_set) & ~en_clr;
      pend <= (pend | lvl) & ~pd_clr;
    end
  end
endmodule

// File: rtl/irqc_lowfind.sv
module irqc_lowfind #(
  parameter int W  = 40,
  parameter int IW = 6
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cascade_irqc.sv
module cascade_irqc
  import irqc_pkg::*;
#(
  parameter int NPRI = NPRI_DEF,
  parameter int NSEC = NSEC_DEF,
  parameter int AW   = AW_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPRI-1:0] prim_src,
  input  logic [NSEC-1:0] sec_src,
  output logic            irq_out
);
  localparam int NWORD = (NPRI + DW - 1) / DW;
  localparam int IW    = $clog2(NPRI);
  localparam int WAW   = AW - 2;

  logic [WAW-1:0] wa;
  logic           aligned;
  assign wa      = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic [NPRI-1:0] p_pend, p_en, p_set, p_enc, p_pclr, p_lvl;
  logic [NSEC-1:0] s_pend, s_en, s_set, s_enc, s_pclr;
  logic [NPRI-1:0] pol_q, typ_q;
  logic [DW-1:0]   spare0_q, spare1_q;
  logic            casc;
  logic [IW-1:0]   top_idx;

  // write strobes, one bit per source
  always_comb begin
    for (int i = 0; i < NPRI; i++) begin
      p_set[i]  = bus_wr && aligned && (int'(wa) == W_PSET   + i / DW) && bus_wdata[i % DW];
      p_enc[i]  = bus_wr && aligned && (int'(wa) == W_PENCLR + i / DW) && bus_wdata[i % DW];
      p_pclr[i] = bus_wr && aligned && (int'(wa) == W_PCLR   + i / DW) && bus_wdata[i % DW];
    end
    for (int i = 0; i < NSEC; i++) begin
      s_set[i]  = bus_wr && aligned && (int'(wa) == W_SSET)   && bus_wdata[i];
      s_enc[i]  = bus_wr && aligned && (int'(wa) == W_SENCLR) && bus_wdata[i];
      s_pclr[i] = bus_wr && aligned && (int'(wa) == W_SCLR)   && bus_wdata[i];
    end
  end

  assign casc  = |(s_pend & s_en);
  assign p_lvl = {prim_src[NPRI-1:1], prim_src[0] | casc};

  irqc_bank #(.W(NSEC)) u_sec (
    .clk(clk), .rst(rst), .lvl(sec_src), .en_set(s_set), .en_clr(s_enc),
    .pd_clr(s_pclr), .pend(s_pend), .en(s_en)
  );

  irqc_bank #(.W(NPRI)) u_pri (
    .clk(clk), .rst(rst), .lvl(p_lvl), .en_set(p_set), .en_clr(p_enc),
    .pd_clr(p_pclr), .pend(p_pend), .en(p_en)
  );

  irqc_lowfind #(.W(NPRI), .IW(IW)) u_find (
    .vec({p_pend[NPRI-1:1] & p_en[NPRI-1:1], 1'b0}),
    .idx(top_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(p_pend & p_en);
  end

  // plain storage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q    <= '0;
      typ_q    <= '0;
      spare0_q <= '0;
      spare1_q <= '0;
    end else if (bus_wr && aligned) begin
      if (int'(wa) == W_SPARE0) spare0_q <= bus_wdata;
      if (int'(wa) == W_SPARE1) spare1_q <= bus_wdata;
      for (int i = 0; i < NPRI; i++) begin
        if (int'(wa) == W_POL + i / DW) pol_q[i] <= bus_wdata[i % DW];
        if (int'(wa) == W_TYP + i / DW) typ_q[i] <= bus_wdata[i % DW];
      end
    end
  end

  // channel map: RAM without reset, plus reset-cleared written flags
  logic [IW-1:0]  ch_mem [0:NPRI-1];
  logic [NPRI-1:0] ch_vld;
  logic [WAW-1:0] ch_off;
  logic [IW-1:0]  ch_i;
  logic           ch_hit;
  logic [IW-1:0]  ch_q;
  logic           ch_sel_q;

  assign ch_off = wa - WAW'(W_CHMAP);
  assign ch_hit = aligned && (int'(wa) >= W_CHMAP) && (int'(ch_off) < NPRI);
  assign ch_i   = ch_off[IW-1:0];

  always_ff @(posedge clk) begin
    if (bus_wr && ch_hit) ch_mem[ch_i] <= bus_wdata[IW-1:0];
    ch_q <= ch_mem[ch_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_vld   <= '0;
      ch_sel_q <= 1'b0;
    end else begin
      if (bus_wr && ch_hit) ch_vld[ch_i] <= 1'b1;
      ch_sel_q <= bus_rd && ch_hit && ch_vld[ch_i];
    end
  end

  // register read path
  function automatic logic [DW-1:0] pword(input logic [NPRI-1:0] v, input int g);
    logic [DW-1:0] r;
    r = '0;
    for (int b = 0; b < DW; b++) begin
      if (g * DW + b < NPRI) r[b] = v[g * DW + b];
    end
    return r;
  endfunction

  logic [DW-1:0] rd_mux, reg_q;
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int g = 0; g < NWORD; g++) begin
        if (int'(wa) == W_PSTAT + g || int'(wa) == W_PCLR + g)   rd_mux = pword(p_pend, g);
        if (int'(wa) == W_PSET + g  || int'(wa) == W_PENCLR + g) rd_mux = pword(p_en, g);
        if (int'(wa) == W_POL + g) rd_mux = pword(pol_q, g);
        if (int'(wa) == W_TYP + g) rd_mux = pword(typ_q, g);
      end
      if (int'(wa) == W_INDEX)  rd_mux = DW'(top_idx);
      if (int'(wa) == W_SPARE0) rd_mux = spare0_q;
      if (int'(wa) == W_SPARE1) rd_mux = spare1_q;
      if (int'(wa) == W_SSTAT || int'(wa) == W_SCLR)   rd_mux = DW'(s_pend);
      if (int'(wa) == W_SSET  || int'(wa) == W_SENCLR) rd_mux = DW'(s_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_q <= '0;
    else if (bus_rd) reg_q <= rd_mux;
  end

  assign bus_rdata = ch_sel_q ? DW'(ch_q) : reg_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NPRI = 40,
  parameter int NSEC = 32,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [NPRI-1:0] p_pend,
  input logic [NPRI-1:0] p_en,
  input logic [NSEC-1:0] s_pend,
  input logic [NSEC-1:0] s_en,
  input logic            irq_out
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!irq_out && p_pend == '0 && p_en == '0 && s_pend == '0 && s_en == '0));

  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h020)) |=>
      ((p_en[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h010)) |=> ((p_pend[31:0] & $past(bus_wdata)) == '0));

  p_sclr_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'('h088)) |=> ((s_pend & $past(bus_wdata[NSEC-1:0])) == '0));

  p_idx_narrow_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'('h040)) |=> (bus_rdata[31:6] == '0));

  p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
    ((|(s_pend & s_en)) && !(bus_wr && bus_addr == AW'('h010) && bus_wdata[0])) |=> p_pend[0]);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (p_en == '0) |=> !irq_out);
endmodule

bind cascade_irqc irqc_chk #(.NPRI(NPRI), .NSEC(NSEC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .p_pend(p_pend), .p_en(p_en),
  .s_pend(s_pend), .s_en(s_en), .irq_out(irq_out)
);

// File: tb/cascade_irqc_bench.sv
module cascade_irqc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [39:0] prim_src = '0;
  logic [31:0] sec_src = '0;
  logic        irq_out;

  always #2 clk = ~clk;

  cascade_irqc u_cascade_irqc (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prim_src(prim_src),
    .sec_src(sec_src), .irq_out(irq_out)
  );

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  int total = 0, bad = 0;
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R9 read with no expectation: got %h", bus_rdata);
      end else begin
        it = sbq.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s addr %h: actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s irq_out: actual %b expected %b", tag, irq_out, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(12'h040, 0, "R1 index");
    rd(12'h020, 0, "R1 enable");
    rd(12'h000, 0, "R1 pending");
    rd(12'h080, 0, "R1 sec pending");
    rd(12'h200, 0, "R1 chmap unwritten");
    // R2 enables
    wr(12'h020, 32'h12);
    rd(12'h020, 32'h12, "R2 set");
    rd(12'h030, 32'h12, "R2 mask at clear offset");
    wr(12'h030, 32'h02);
    rd(12'h020, 32'h10, "R2 clear");
    wr(12'h020, 32'h0);
    rd(12'h020, 32'h10, "R2 zero bits no effect");
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, 32'hFF, "R2 upper word width");
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h024, 32'h0, "R2 upper clear");
    // R3 pending regardless of enable
    prim_src[4] = 1'b1; prim_src[9] = 1'b1;
    idle(3);
    rd(12'h000, 32'h210, "R3 pending");
    rd(12'h040, 32'd4, "R5 index single");
    chk_irq(1'b1, "R7 enabled pending");
    // R5 lowest wins
    wr(12'h020, 32'h2);
    prim_src[1] = 1'b1;
    idle(3);
    rd(12'h040, 32'd1, "R5 lowest wins");
    // R4 one-cycle drop then relatch
    wr(12'h010, 32'h2);
    rd(12'h000, 32'h210, "R4 dropped next cycle");
    idle(2);
    rd(12'h000, 32'h212, "R4 relatched");
    prim_src[1] = 1'b0;
    wr(12'h010, 32'h2);
    idle(2);
    rd(12'h014, 32'h0, "R3 upper word alias");
    rd(12'h010, 32'h210, "R4 stays clear");
    // R7 lag of one cycle
    prim_src[4] = 1'b0;
    wr(12'h010, 32'h10);
    chk_irq(1'b1, "R7 one-cycle lag");
    idle(1);
    chk_irq(1'b0, "R7 drops");
    // upper word source
    prim_src[35] = 1'b1;
    wr(12'h024, 32'h8);
    idle(3);
    rd(12'h004, 32'h8, "R3 upper word bit3");
    rd(12'h040, 32'd35, "R5 upper source");
    chk_irq(1'b1, "R7 upper source");
    wr(12'h020, 32'h200);
    rd(12'h040, 32'd9, "R5 lower beats upper");
    prim_src[35] = 1'b0; prim_src[9] = 1'b0;
    wr(12'h034, 32'h8);
    wr(12'h030, 32'h200);
    wr(12'h014, 32'h8);
    wr(12'h010, 32'h200);
    idle(2);
    rd(12'h040, 32'd0, "R5 none active");
    chk_irq(1'b0, "R7 none active");
    // R6 cascade
    sec_src[5] = 1'b1; sec_src[20] = 1'b1;
    idle(3);
    rd(12'h080, 32'h0010_0020, "R6 raw sec pending");
    rd(12'h000, 32'h0, "R6 no cascade while masked");
    wr(12'h090, 32'h0010_0000);
    idle(3);
    rd(12'h000, 32'h1, "R6 cascade into source 0");
    rd(12'h098, 32'h0010_0000, "R6 sec enable mask");
    chk_irq(1'b0, "R7 primary 0 masked");
    wr(12'h020, 32'h1);
    idle(2);
    chk_irq(1'b1, "R7 cascade reaches cpu");
    rd(12'h040, 32'd0, "R5 cascade only gives 0");
    wr(12'h098, 32'h0010_0000);
    wr(12'h010, 32'h1);
    idle(3);
    rd(12'h000, 32'h0, "R6 cascade gone");
    chk_irq(1'b0, "R7 after cascade clear");
    rd(12'h088, 32'h0010_0020, "R6 sec pending kept");
    sec_src[5] = 1'b0;
    wr(12'h088, 32'h20);
    idle(1);
    rd(12'h080, 32'h0010_0000, "R4 sec clear");
    // R8 storage
    wr(12'h044, 32'hA5A5_1234);
    rd(12'h044, 32'hA5A5_1234, "R8 spare0");
    wr(12'h0A0, 32'hDEAD_BEEF);
    rd(12'h0A0, 32'hDEAD_BEEF, "R8 spare1");
    wr(12'h054, 32'hFFFF_FF3C);
    rd(12'h054, 32'h3C, "R8 polarity upper");
    wr(12'h060, 32'h1357_9BDF);
    rd(12'h060, 32'h1357_9BDF, "R8 type lower");
    wr(12'h29C, 32'd39);
    rd(12'h29C, 32'd39, "R8 chmap entry 39");
    wr(12'h21C, 32'hFFFF_FFFF);
    rd(12'h21C, 32'h3F, "R8 chmap width");
    // R9 unmapped, out of range and misaligned
    wr(12'h2A0, 32'h15);
    rd(12'h2A0, 32'h0, "R9 chmap beyond 39");
    rd(12'h300, 32'h0, "R9 unmapped");
    wr(12'h046, 32'h0);
    rd(12'h046, 32'h0, "R9 misaligned read");
    rd(12'h044, 32'hA5A5_1234, "R9 misaligned write ignored");
    // bulk disable and clear
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h024, 32'hFF);
    wr(12'h090, 32'hFFFF_FFFF);
    sec_src[20] = 1'b0;
    idle(1);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFF);
    wr(12'h098, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFF);
    wr(12'h088, 32'hFFFF_FFFF);
    idle(2);
    rd(12'h020, 32'h0, "R2 bulk disable lower");
    rd(12'h024, 32'h0, "R2 bulk disable upper");
    rd(12'h090, 32'h0, "R6 bulk sec disable");
    rd(12'h080, 32'h0, "R4 bulk sec clear");
    rd(12'h000, 32'h0, "R4 bulk primary clear");
    chk_irq(1'b0, "R7 after bulk clear");
    idle(3);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 %0d reads never returned: actual %0d expected 0", sbq.size(), sbq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule